// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every data beat of a memory read or write burst. A column command hands it a start column, a length code and a type bit. From the next cycle it presents one column per clock, with a valid flag, and it raises a last flag on the closing beat of a fixed-length burst.

Fixed bursts of 2, 4, 8 or 16 beats stay inside an aligned block the size of the burst. Sequential type counts upward and wraps inside that block. Interleaved type forms the low bits as the start's low bits XOR the beat index. In both types the column bits above the block are held.

A page-length mode walks the whole row, wrapping from the top column to column 0. It runs until a new column command or a stop request ends it. The page width is a parameter, so one design serves both page-size options. A new column command cuts off any running burst. A stop request ends the running burst at once.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `valid_o` and `last_o` are 0.
- R2: A start with length code 1, 2, 3 or 4 makes `valid_o` high for exactly 2, 4, 8 or 16 consecutive cycles, beginning in the cycle after the start edge, unless the burst is interrupted.
- R3: With `type_i`=0 (sequential), beat k has column bits [log2(L)-1:0] equal to (start low bits + k) mod L. The bits above that field equal the start column's. For example, L=4 from column 2 gives 2-3-0-1.
- R4: With `type_i`=1 (interleaved) and a fixed length, beat k has low bits equal to the start's low log2(L) bits XOR k. The upper bits are held.
- R5: Length code 7 selects page mode. The column increments by one per cycle, wraps from 2^COL_W-1 to 0, and continues until interrupted. `type_i` has no effect in this mode.
- R6: `last_o` is 1 only on the final beat of a fixed-length burst and is never 1 in page mode.
- R7: A start with a valid code during a running burst abandons it. The next cycle shows the new start column as beat 0.
- R8: `stop_i` high at an edge with no accepted start makes `valid_o` 0 from the next cycle. When the block is idle, `stop_i` has no effect.
- R9: Length codes 0, 5 and 6 are reserved. A start carrying one of them is ignored: an idle block stays idle, and a running burst continues with its next beat.
- R10: When a valid start and `stop_i` are high at the same edge, the start wins and the new burst begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Column command strobe |
| start_col_i | input | COL_W | Start column of the burst |
| len_code_i | input | 3 | Length code: 1=2, 2=4, 3=8, 4=16, 7=page |
| type_i | input | 1 | 0 sequential, 1 interleaved |
| stop_i | input | 1 | Stop request for the running burst |
| col_o | output | COL_W | Column of the current beat |
| valid_o | output | 1 | A beat is presented |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
The bench checks the following cases, each chosen to catch a specific mistake:

- **Wrap inside the aligned block**, for lengths 2, 4, 8 and 16 with high start offsets. A design that carries into the upper bits would step out of the block, for example 0x3F3 going to 0x400 instead of wrapping to 0x3F0.
- **Interleaved order against sequential order.** Swapping the two types produces a different order from beat 1 onward.
- **Page-mode crossing from the top column to 0.** A design that stops early here, or raises last, is caught.
- **Interruption by a start and by a stop.** The bench looks for a stale beat after the new start or after the stop.
- **Reserved codes and start-plus-stop priority.** A reserved code that restarts or kills the burst shows up as a wrong next column. Stop given priority over start shows up as an idle cycle where beat 0 belongs.

// File: rtl/bcs_pkg.sv
// Shared definitions for the burst column sequencer: length codes and the
// decoded burst configuration. Assumes a 3-bit length code on the port.
package bcs_pkg;
    localparam int LC_W = 3;

    localparam logic [LC_W-1:0] LC_B2   = 3'd1;
    localparam logic [LC_W-1:0] LC_B4   = 3'd2;
    localparam logic [LC_W-1:0] LC_B8   = 3'd3;
    localparam logic [LC_W-1:0] LC_B16  = 3'd4;
    localparam logic [LC_W-1:0] LC_PAGE = 3'd7;

    // ok: code is legal; page: whole-row mode; lg: log2 of beats (fixed modes)
    typedef struct packed {
        logic       ok;
        logic       page;
        logic [2:0] lg;
    } len_cfg_t;
endpackage

// File: rtl/bcs_len_decode.sv
// Length code decoder. Turns the length code into a legality flag, a
// page-mode flag and log2 of the burst length. Purely combinational.
// Assumes: reserved codes only need to be flagged, not remapped.
module bcs_len_decode
    import bcs_pkg::*;
(
    input  logic [LC_W-1:0] code_i,
    output len_cfg_t        cfg_o
);
    // Map each code; reserved codes come out with ok = 0.
    always_comb begin
        cfg_o = '{ok: 1'b0, page: 1'b0, lg: 3'd0};
        unique case (code_i)
            LC_B2:   cfg_o = '{ok: 1'b1, page: 1'b0, lg: 3'd1};
            LC_B4:   cfg_o = '{ok: 1'b1, page: 1'b0, lg: 3'd2};
            LC_B8:   cfg_o = '{ok: 1'b1, page: 1'b0, lg: 3'd3};
            LC_B16:  cfg_o = '{ok: 1'b1, page: 1'b0, lg: 3'd4};
            LC_PAGE: cfg_o = '{ok: 1'b1, page: 1'b1, lg: 3'd0};
            default: cfg_o = '{ok: 1'b0, page: 1'b0, lg: 3'd0};
        endcase
    end
endmodule

// File: rtl/bcs_col_form.sv
// Column former. From the held start column and the beat index it builds
// the beat's column: the bits above the burst block come from the start,
// and the bits inside the block are either a sum (sequential) or an XOR
// (interleaved). Page mode uses the full width as the block.
// Also flags the final beat of a fixed burst.
// Assumes: COL_W >= 4 and beat_i < burst length.
module bcs_col_form #(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [2:0]       lg_i,
    input  logic             page_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o,
    output logic             fin_o
);
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] sum;
    logic [COL_W-1:0] low;

    // Block mask: whole row in page mode, else L-1.
    always_comb begin
        if (page_i) mask = '1;
        else        mask = (COL_W'(1) << lg_i) - COL_W'(1);
    end

    // Inner bits follow the selected order; the start keeps the upper bits.
    always_comb begin
        sum   = base_i + beat_i;
        low   = (ilv_i && !page_i) ? (base_i ^ beat_i) : sum;
        col_o = (base_i & ~mask) | (low & mask);
    end

    // The final beat of a fixed burst has index L-1; page mode never ends.
    always_comb fin_o = !page_i && (beat_i == mask);
endmodule

// File: rtl/bcs_beat_ctrl.sv
// Beat controller. Holds the accepted burst (start column, length, type)
// and a beat index, advances once per cycle, and ends the burst on its
// final beat or on a stop. An accepted start always reloads, so it
// interrupts any burst in flight and outranks a stop in the same cycle.
// Assumes: fin_i comes from the column former for the current beat.
module bcs_beat_ctrl
    import bcs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  len_cfg_t         cfg_i,
    input  logic             type_i,
    input  logic             stop_i,
    input  logic             fin_i,
    output logic             act_o,
    output logic [COL_W-1:0] base_o,
    output logic [COL_W-1:0] beat_o,
    output logic [2:0]       lg_o,
    output logic             page_o,
    output logic             ilv_o
);
    logic take;

    // A start is taken only when its length code is legal.
    always_comb take = start_i && cfg_i.ok;

    // Burst state: load on a taken start, else stop, finish or step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_o  <= 1'b0;
            base_o <= '0;
            beat_o <= '0;
            lg_o   <= 3'd0;
            page_o <= 1'b0;
            ilv_o  <= 1'b0;
        end else if (take) begin
            act_o  <= 1'b1;
            base_o <= start_col_i;
            beat_o <= '0;
            lg_o   <= cfg_i.lg;
            page_o <= cfg_i.page;
            ilv_o  <= type_i;
        end else if (stop_i) begin
            act_o  <= 1'b0;
        end else if (act_o) begin
            if (fin_i) act_o <= 1'b0;
            else       beat_o <= beat_o + COL_W'(1);
        end
    end

    // R8: a stop with no taken start leaves the block idle next cycle
    p_stop_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !(start_i && cfg_i.ok)) |=> !act_o);

    // R2: the final beat of a fixed burst is followed by idle
    p_final_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (act_o && fin_i && !(start_i && cfg_i.ok)) |=> !act_o);

    // R9: without a legal start an idle block stays idle
    p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_o && !(start_i && cfg_i.ok)) |=> !act_o);
endmodule

// File: rtl/burst_col_seq.sv
// Burst column sequencer top. Decodes the length code, keeps the burst
// state and forms the per-beat column. valid/last come from registered
// state, so beat 0 appears in the cycle after the start edge.
// Assumes: COL_W >= 4 (room for a 16-beat block).
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       len_code_i,
    input  logic             type_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o
);
    len_cfg_t         cfg;
    logic             act;
    logic [COL_W-1:0] base;
    logic [COL_W-1:0] beat;
    logic [2:0]       lg;
    logic             page;
    logic             ilv;
    logic             fin;

    bcs_len_decode u_dec (
        .code_i (len_code_i),
        .cfg_o  (cfg)
    );

    bcs_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .cfg_i       (cfg),
        .type_i      (type_i),
        .stop_i      (stop_i),
        .fin_i       (fin),
        .act_o       (act),
        .base_o      (base),
        .beat_o      (beat),
        .lg_o        (lg),
        .page_o      (page),
        .ilv_o       (ilv)
    );

    bcs_col_form #(.COL_W(COL_W)) u_form (
        .base_i (base),
        .beat_i (beat),
        .lg_i   (lg),
        .page_i (page),
        .ilv_i  (ilv),
        .col_o  (col_o),
        .fin_o  (fin)
    );

    // Outputs: beat presence and final-beat marker.
    always_comb begin
        valid_o = act;
        last_o  = act && fin;
    end

    // R7: a legal start shows its own column as beat 0 next cycle
    p_start_col_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && cfg.ok) |=> (valid_o && col_o == $past(start_col_i)));

    // R3: a continuing beat always moves to a different column
    p_beat_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o && !start_i && !stop_i) |=> (valid_o && col_o != $past(col_o)));
endmodule

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;
    localparam int CW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [CW-1:0] start_col_i = '0;
    logic [2:0]    len_code_i = 3'd0;
    logic          type_i = 1'b0;
    logic          stop_i = 1'b0;
    logic [CW-1:0] col_o;
    logic          valid_o;
    logic          last_o;

    int checks = 0;
    int errors = 0;
    logic [CW-1:0] expq[$];

    always #4 clk = ~clk;

    burst_col_seq #(.COL_W(CW)) u_burst_col_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .len_code_i(len_code_i), .type_i(type_i), .stop_i(stop_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
    );

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic chk(input string req, input bit ev, input logic [CW-1:0] ec, input bit el);
        checks++;
        if (valid_o !== ev || (ev && (col_o !== ec || last_o !== el)) || (!ev && last_o !== 1'b0)) begin
            errors++;
            $display("FAIL %s: valid=%0b col=%h last=%0b expected valid=%0b col=%h last=%0b",
                     req, valid_o, col_o, last_o, ev, ec, el);
        end
    endtask

    // Drive a start for one edge; beat 0 is visible on return.
    task automatic issue(input logic [CW-1:0] c, input logic [2:0] code, input bit t);
        start_i = 1'b1; start_col_i = c; len_code_i = code; type_i = t;
        step();
        start_i = 1'b0;
    endtask

    // Walk expq beat by beat; fixed bursts must end with last then idle.
    task automatic walk(input string req, input bit fixed);
        for (int i = 0; i < expq.size(); i++) begin
            if (i > 0) step();
            chk(req, 1'b1, expq[i], fixed && (i == expq.size() - 1));
        end
        if (fixed) begin
            step();
            chk(req, 1'b0, '0, 1'b0);
        end
    endtask

    task automatic t_reset();
        chk("R1 in reset", 1'b0, '0, 1'b0);
        rst_n = 1'b1;
        step();
        chk("R1 after release", 1'b0, '0, 1'b0);
    endtask

    task automatic t_seq();
        issue(10'h012, 3'd2, 1'b0);
        expq = '{10'h012, 10'h013, 10'h010, 10'h011};
        walk("R3 R2 len4 seq", 1'b1);
        issue(10'h1A6, 3'd3, 1'b0);
        expq = '{10'h1A6, 10'h1A7, 10'h1A0, 10'h1A1, 10'h1A2, 10'h1A3, 10'h1A4, 10'h1A5};
        walk("R3 R6 len8 seq", 1'b1);
        issue(10'h005, 3'd1, 1'b0);
        expq = '{10'h005, 10'h004};
        walk("R2 len2 seq", 1'b1);
        issue(10'h3F3, 3'd4, 1'b0);
        expq = '{10'h3F3, 10'h3F4, 10'h3F5, 10'h3F6, 10'h3F7, 10'h3F8, 10'h3F9, 10'h3FA,
                 10'h3FB, 10'h3FC, 10'h3FD, 10'h3FE, 10'h3FF, 10'h3F0, 10'h3F1, 10'h3F2};
        walk("R2 R3 len16 seq", 1'b1);
    endtask

    task automatic t_ilv();
        issue(10'h025, 3'd3, 1'b1);
        expq = '{10'h025, 10'h024, 10'h027, 10'h026, 10'h021, 10'h020, 10'h023, 10'h022};
        walk("R4 len8 interleaved", 1'b1);
        issue(10'h00B, 3'd2, 1'b1);
        expq = '{10'h00B, 10'h00A, 10'h009, 10'h008};
        walk("R4 len4 interleaved", 1'b1);
    endtask

    task automatic t_page();
        issue(10'h3FD, 3'd7, 1'b1);
        expq = '{10'h3FD, 10'h3FE, 10'h3FF, 10'h000, 10'h001, 10'h002};
        walk("R5 R6 page wrap", 1'b0);
        stop_i = 1'b1;
        step();
        stop_i = 1'b0;
        chk("R8 stop ends page burst", 1'b0, '0, 1'b0);
        stop_i = 1'b1;
        step();
        stop_i = 1'b0;
        chk("R8 stop while idle", 1'b0, '0, 1'b0);
    endtask

    task automatic t_interrupt();
        issue(10'h040, 3'd3, 1'b0);
        chk("R7 first burst b0", 1'b1, 10'h040, 1'b0);
        step(); chk("R7 first burst b1", 1'b1, 10'h041, 1'b0);
        step(); chk("R7 first burst b2", 1'b1, 10'h042, 1'b0);
        issue(10'h081, 3'd2, 1'b0);
        expq = '{10'h081, 10'h082, 10'h083, 10'h080};
        walk("R7 interrupting burst", 1'b1);
    endtask

    task automatic t_reserved();
        issue(10'h055, 3'd5, 1'b0);
        chk("R9 code5 idle", 1'b0, '0, 1'b0);
        issue(10'h055, 3'd0, 1'b0);
        chk("R9 code0 idle", 1'b0, '0, 1'b0);
        issue(10'h010, 3'd2, 1'b0);
        chk("R9 burst b0", 1'b1, 10'h010, 1'b0);
        issue(10'h200, 3'd6, 1'b1);
        expq = '{10'h011, 10'h012, 10'h013};
        walk("R9 code6 ignored mid-burst", 1'b1);
    endtask

    task automatic t_start_stop();
        issue(10'h100, 3'd7, 1'b0);
        chk("R10 page b0", 1'b1, 10'h100, 1'b0);
        stop_i = 1'b1;
        issue(10'h007, 3'd1, 1'b0);
        stop_i = 1'b0;
        expq = '{10'h007, 10'h006};
        walk("R10 start beats stop", 1'b1);
    endtask

    initial begin
        step(); step(); step();
        t_reset();
        t_seq();
        t_ilv();
        t_page();
        t_interrupt();
        t_reserved();
        t_start_stop();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule